// File: doc/BRIEF.md
# Interleaved Leg Count and Current Sharing Controller

This block sits between an outer regulator and the pulse generators of a three-leg interleaved half-bridge converter. Once per control period, a sample strobe delivers the load current, the current in each leg and a base duty word. The block decides how many legs switch and produces a duty word and an enable flag for each leg.

The number of switching legs follows the magnitude of the load current. A hysteretic state machine adds legs in ascending order and removes them in descending order, and it moves by at most one leg per update. Leg 0 carries the reference current. Every other active leg keeps an integrating trim that it adds to the base duty. The trim pulls that leg's current toward the reference current, so a single loop balances the legs however many of them are active.

Switching a leg on or off only gates its pulses and clears its trim. The outer loops, the PWM carrier, dead time and sensing belong to other blocks.

Top module: `leg_shed_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all `leg_en` bits and all `duty_out` words become 0, the controller returns to the one-leg state and all trims are cleared.
- R2: `leg_en[0]` is 1 exactly when the last sampled load magnitude is nonzero. Its duty word is then `base_duty`; otherwise it is 0.
- R3: `leg_en[1]` turns on when the sampled magnitude is strictly above 4608 (18 A, at 1/256 A per LSB). It turns off only when the magnitude is strictly below 3840 (15 A). Between the two values it holds.
- R4: `leg_en[2]` turns on when the magnitude is strictly above 10240 (40 A) and the controller is in the two-leg state. It turns off when the magnitude is strictly below 8960 (35 A). `leg_en[2]` is never 1 while `leg_en[1]` is 0.
- R5: Each update changes the leg count by at most one. A jump from one to three legs therefore takes two updates, and so does a drop from three to one.
- R6: The outputs change only on the clock edge at which `sample_valid` is sampled high. With the strobe low they hold, whatever the other inputs do.
- R7: On each update an active leg i (i = 1, 2) adds floor((leg_cur[0] − leg_cur[i]) / 16) to its trim. The trim is then limited to ±512, and the leg's duty word is base_duty + trim.
- R8: A leg that is off outputs duty 0 and has its trim reset to 0. When it turns on again, its trim starts from the first new step.
- R9: The load current is compared by its absolute value, so negative load currents add and remove legs exactly as positive ones do.
- R10: Trimmed duty words saturate to the range 0 to 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | One-cycle strobe that starts an update |
| load_cur | input | 16 | Signed load current, 1/256 A per LSB |
| leg_cur | input | 3x16 | Signed leg currents; element 0 is the sharing reference |
| base_duty | input | 12 | Unsigned duty word from the outer regulator |
| duty_out | output | 3x12 | Duty word for each leg |
| leg_en | output | 3 | Pulse-enable flag for each leg |

## Verification
The hardest cases to reach are the trim limits and the clearing of a trim when its leg drops out. The third leg must first be brought in, one step at a time, with large current differences, and then shed back while its trim is still nonzero. The directed sequence does this in order. It ramps the load to the three-leg state, drives large leg-current offsets until both the ±512 trim limit and the 0/4095 duty limits are hit, and then sheds and re-adds legs. Re-adding a leg shows that its trim restarts from a single step.

// File: rtl/leg_shed_pkg.sv
package leg_shed_pkg;
    localparam int CUR_W     = 16;
    localparam int DUTY_W    = 12;
    localparam int NUM_LEGS  = 3;
    localparam int K_SHIFT   = 4;
    localparam int TRIM_LIM  = 512;
    localparam int AMP_LSB   = 256;
    localparam int ADD_TWO   = 18 * AMP_LSB;
    localparam int DROP_TWO  = 15 * AMP_LSB;
    localparam int ADD_THREE = 40 * AMP_LSB;
    localparam int DROP_THREE = 35 * AMP_LSB;
    localparam int DUTY_FULL = (1 << DUTY_W) - 1;
    localparam int TRIM_W    = DUTY_W + 1;

    typedef logic signed [CUR_W-1:0] cur_t;
    typedef logic [CUR_W:0]          mag_t;
    typedef logic [DUTY_W-1:0]       duty_t;
    typedef logic signed [TRIM_W-1:0] trim_t;

    typedef enum logic [1:0] {
        LEGS_ONE   = 2'd1,
        LEGS_TWO   = 2'd2,
        LEGS_THREE = 2'd3
    } leg_cnt_e;

    function automatic mag_t cur_mag(input cur_t x);
        logic signed [CUR_W:0] w;
        w = CUR_W'(x) < 0 ? -(CUR_W+1)'(x) : (CUR_W+1)'(x);
        w = x[CUR_W-1] ? -{x[CUR_W-1], x} : {x[CUR_W-1], x};
        return mag_t'(w);
    endfunction

    function automatic duty_t duty_clamp(input duty_t base, input trim_t trim);
        logic signed [DUTY_W+1:0] s;
        s = $signed({2'b00, base}) + (DUTY_W+2)'(trim);
        if (s < 0)
            return '0;
        else if (s > (DUTY_W+2)'(DUTY_FULL))
            return duty_t'(DUTY_FULL);
        else
            return s[DUTY_W-1:0];
    endfunction
endpackage

// File: rtl/leg_count_fsm.sv
module leg_count_fsm
    import leg_shed_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sample_valid,
    input  mag_t     load_mag,
    output leg_cnt_e cnt_d,
    output leg_cnt_e cnt_q
);
    always_comb begin
        cnt_d = cnt_q;
        if (sample_valid) begin
            unique case (cnt_q)
                LEGS_ONE:
                    if (load_mag > mag_t'(ADD_TWO)) cnt_d = LEGS_TWO;
                LEGS_TWO:
                    if (load_mag > mag_t'(ADD_THREE))     cnt_d = LEGS_THREE;
                    else if (load_mag < mag_t'(DROP_TWO)) cnt_d = LEGS_ONE;
                LEGS_THREE:
                    if (load_mag < mag_t'(DROP_THREE)) cnt_d = LEGS_TWO;
                default: cnt_d = LEGS_ONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= LEGS_ONE;
        else     cnt_q <= cnt_d;
    end

    // R5
    one_step_chk: assert property (@(posedge clk) disable iff (rst)
        !(($past(cnt_q) == LEGS_ONE && cnt_q == LEGS_THREE) ||
          ($past(cnt_q) == LEGS_THREE && cnt_q == LEGS_ONE)));

    // R6
    cnt_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q)) |-> $past(sample_valid));
endmodule

// File: rtl/leg_trim.sv
module leg_trim
    import leg_shed_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sample_valid,
    input  logic  en_next,
    input  cur_t  ref_cur,
    input  cur_t  own_cur,
    input  duty_t base_duty,
    output logic  en_q,
    output duty_t duty_q
);
    localparam int ACC_W = CUR_W + 2;

    trim_t trim_q, trim_d;
    logic signed [CUR_W:0]   err;
    logic signed [CUR_W:0]   step;
    logic signed [ACC_W-1:0] acc;

    always_comb begin
        err  = (CUR_W+1)'(ref_cur) - (CUR_W+1)'(own_cur);
        step = err >>> K_SHIFT;
        acc  = ACC_W'(trim_q) + ACC_W'(step);
        if (!en_next)
            trim_d = '0;
        else if (acc > ACC_W'(TRIM_LIM))
            trim_d = trim_t'(TRIM_LIM);
        else if (acc < -ACC_W'(TRIM_LIM))
            trim_d = -trim_t'(TRIM_LIM);
        else
            trim_d = trim_t'(acc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trim_q <= '0;
            en_q   <= 1'b0;
            duty_q <= '0;
        end else if (sample_valid) begin
            trim_q <= trim_d;
            en_q   <= en_next;
            duty_q <= en_next ? duty_clamp(base_duty, trim_d) : '0;
        end
    end

    // R7
    trim_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (trim_q <= trim_t'(TRIM_LIM)) && (trim_q >= -trim_t'(TRIM_LIM)));

    // R6
    duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(sample_valid) |-> $stable(duty_q));
endmodule

// File: rtl/leg_shed_ctrl.sv
module leg_shed_ctrl
    import leg_shed_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          sample_valid,
    input  logic signed [CUR_W-1:0]       load_cur,
    input  logic [NUM_LEGS-1:0][CUR_W-1:0] leg_cur,
    input  logic [DUTY_W-1:0]             base_duty,
    output logic [NUM_LEGS-1:0][DUTY_W-1:0] duty_out,
    output logic [NUM_LEGS-1:0]           leg_en
);
    mag_t     load_mag;
    leg_cnt_e cnt_d, cnt_q;

    assign load_mag = cur_mag(load_cur);

    leg_count_fsm i_fsm (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .load_mag     (load_mag),
        .cnt_d        (cnt_d),
        .cnt_q        (cnt_q)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        if (g == 0) begin : g_ref
            logic  en_r;
            duty_t duty_r;
            always_ff @(posedge clk) begin
                if (rst) begin
                    en_r   <= 1'b0;
                    duty_r <= '0;
                end else if (sample_valid) begin
                    en_r   <= (load_mag != '0);
                    duty_r <= (load_mag != '0) ? base_duty : '0;
                end
            end
            assign leg_en[g]   = en_r;
            assign duty_out[g] = duty_r;
        end else begin : g_trim
            logic en_next;
            assign en_next = (int'(cnt_d) > g);
            leg_trim i_trim (
                .clk          (clk),
                .rst          (rst),
                .sample_valid (sample_valid),
                .en_next      (en_next),
                .ref_cur      (cur_t'(leg_cur[0])),
                .own_cur      (cur_t'(leg_cur[g])),
                .base_duty    (base_duty),
                .en_q         (leg_en[g]),
                .duty_q       (duty_out[g])
            );
        end
    end

    // R4
    leg_order_chk: assert property (@(posedge clk) disable iff (rst)
        leg_en[2] |-> leg_en[1]);

    // R3
    leg_add_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(leg_en[1]) |-> $past(sample_valid));
endmodule

// File: tb/test_leg_shed_ctrl.sv
`timescale 1ns/1ps
module test_leg_shed_ctrl;
    logic clk = 0;
    logic rst = 1;
    logic sample_valid = 0;
    logic signed [15:0] load_cur = 0;
    logic [2:0][15:0] leg_cur = '0;
    logic [11:0] base_duty = 0;
    logic [2:0][11:0] duty_out;
    logic [2:0] leg_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model state
    int m_cnt = 1;
    int m_trim [3];
    logic [2:0] m_en;
    int m_duty [3];

    always #5 clk = ~clk;

    leg_shed_ctrl i_leg_shed_ctrl (
        .clk(clk), .rst(rst), .sample_valid(sample_valid),
        .load_cur(load_cur), .leg_cur(leg_cur), .base_duty(base_duty),
        .duty_out(duty_out), .leg_en(leg_en)
    );

    function automatic int lim(int v, int lo, int hi);
        return v < lo ? lo : (v > hi ? hi : v);
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check({req, " leg_en"}, int'(leg_en), int'(m_en));
        for (int i = 0; i < 3; i++)
            check({req, " duty"}, int'(duty_out[i]), m_duty[i]);
    endtask

    task automatic model_reset();
        m_cnt = 1;
        m_en = '0;
        for (int i = 0; i < 3; i++) begin
            m_trim[i] = 0;
            m_duty[i] = 0;
        end
    endtask

    task automatic model_update(int ld, int l0, int l1, int l2, int base);
        int mag;
        int lc [3];
        lc[0] = l0; lc[1] = l1; lc[2] = l2;
        mag = ld < 0 ? -ld : ld;
        case (m_cnt)
            1: if (mag > 4608) m_cnt = 2;
            2: if (mag > 10240) m_cnt = 3; else if (mag < 3840) m_cnt = 1;
            default: if (mag < 8960) m_cnt = 2;
        endcase
        m_en[0] = (mag != 0);
        m_duty[0] = m_en[0] ? base : 0;
        for (int i = 1; i < 3; i++) begin
            m_en[i] = (m_cnt > i);
            if (m_en[i]) begin
                m_trim[i] = lim(m_trim[i] + ((l0 - lc[i]) >>> 4), -512, 512);
                m_duty[i] = lim(base + m_trim[i], 0, 4095);
            end else begin
                m_trim[i] = 0;
                m_duty[i] = 0;
            end
        end
    endtask

    task automatic upd(string req, int ld, int l0, int l1, int l2, int base);
        @(negedge clk);
        load_cur = 16'(ld);
        leg_cur[0] = 16'(l0); leg_cur[1] = 16'(l1); leg_cur[2] = 16'(l2);
        base_duty = 12'(base);
        sample_valid = 1;
        @(negedge clk);
        sample_valid = 0;
        model_update(ld, l0, l1, l2, base);
        check_all(req);
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        model_reset();
        check_all("R1 reset");
        rst = 0;
    endtask

    task automatic t_ramp_up();
        upd("R2 light load", 2560, 1000, 1000, 1000, 2000);
        upd("R3 at 18A stays one", 4608, 1000, 1000, 1000, 2000);
        upd("R3 above 18A adds", 4609, 1000, 1000, 1000, 2000);
        upd("R4 above 40A adds", 12800, 1000, 1000, 1000, 2000);
    endtask

    task automatic t_hysteresis();
        upd("R4 36A holds three", 9216, 1000, 1000, 1000, 2000);
        upd("R4 at 35A holds", 8960, 1000, 1000, 1000, 2000);
        upd("R4 below 35A drops", 8959, 1000, 1000, 1000, 2000);
        upd("R3 16A holds two", 4096, 1000, 1000, 1000, 2000);
        upd("R3 at 15A holds", 3840, 1000, 1000, 1000, 2000);
        upd("R3 below 15A drops", 3839, 1000, 1000, 1000, 2000);
    endtask

    task automatic t_one_step();
        upd("R5 one to big load", 15000, 1000, 1000, 1000, 2000);
        upd("R5 second step", 15000, 1000, 1000, 1000, 2000);
        upd("R5 three to zero", 0, 1000, 1000, 1000, 2000);
        upd("R5 second drop", 0, 1000, 1000, 1000, 2000);
    endtask

    task automatic t_negative();
        upd("R9 negative 20A", -5120, 1000, 1000, 1000, 1500);
        upd("R9 negative 45A", -11520, 1000, 1000, 1000, 1500);
        upd("R9 negative 10A", -2560, 1000, 1000, 1000, 1500);
        upd("R9 negative 10A again", -2560, 1000, 1000, 1000, 1500);
    endtask

    task automatic t_trim();
        upd("R7 trim up", 5120, 5000, 4000, 5400, 2000);
        upd("R7 trim up", 11520, 5000, 4000, 5400, 2000);
        upd("R7 trim accumulate", 11520, 5000, 4000, 5400, 2000);
        upd("R7 odd negative step", 11520, 5000, 5001, 5017, 2000);
    endtask

    task automatic t_sat();
        upd("R7 trim limit", 11520, 10000, 0, 20000, 3800);
        upd("R10 duty high limit", 11520, 10000, 0, 20000, 3800);
        upd("R10 duty low limit", 11520, 10000, 0, 20000, 100);
    endtask

    task automatic t_shed();
        upd("R8 shed leg 3", 5120, 10000, 0, 20000, 2000);
        upd("R8 re-add leg 3", 11520, 10000, 0, 9000, 2000);
        upd("R8 shed to two", 5120, 10000, 0, 9000, 2000);
        upd("R8 shed to one", 1000, 10000, 0, 9000, 2000);
        upd("R8 re-add leg 2", 5120, 10000, 9200, 9000, 2000);
    endtask

    task automatic t_hold();
        @(negedge clk);
        load_cur = 16'(12000);
        leg_cur[0] = 16'(3000); leg_cur[1] = 16'(0);
        base_duty = 12'(100);
        repeat (3) @(negedge clk);
        check_all("R6 hold without strobe");
    endtask

    task automatic t_zero();
        upd("R2 zero load", 0, 1000, 1000, 1000, 2000);
        upd("R2 zero load stays", 0, 1000, 1000, 1000, 2000);
        upd("R2 small load", 1, 1000, 1000, 1000, 777);
    endtask

    initial begin
        model_reset();
        t_reset();
        t_ramp_up();
        t_hysteresis();
        t_one_step();
        t_negative();
        t_trim();
        t_sat();
        t_shed();
        t_hold();
        t_zero();
        upd("R1 pre reset", 12000, 1000, 1000, 1000, 2000);
        t_reset();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule